// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven through one 32-bit control word. Software writes the word to load a timeout, to start the countdown, or to stop it. Once the stored word has its run bit set, the watchdog is armed against stray writes. A new write is taken only if its key field is the bitwise inverse of the key in the last word that was taken. Any other write is dropped without effect.

The countdown advances only on cycles where the slow tick enable is high. When it runs out the first time, the block raises a non-maskable interrupt and reloads a short grace count of ten ticks. If that grace count also runs out, the block raises a reset request. The reset request stays high until the block itself is reset. Any accepted write drops the interrupt and returns the block to its first stage, so the handler can save the system by servicing the watchdog during the grace window.

The write port is a plain strobe and is sampled on every rising clock edge. It has no back-pressure, because a control write always completes in the cycle it is presented. The tick enable and both outputs are plain level signals.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `nmi_o` and `rst_req_o` are low, the counter is stopped, and the stored control word is zero, which means disarmed.
- R2: An accepted write loads the count from bits [7:0]. The counter drops by one on each clock edge where `tick_en` is high, and it expires on exactly the Nth such tick. Cycles with `tick_en` low do not count.
- R3: A count field of zero loads 256 ticks.
- R4: Bit 8 of an accepted write starts the countdown when it is 1 and stops it when it is 0. A stopped counter never expires, however many ticks arrive.
- R5: While the stored bit 8 is 1, a write is accepted only if its bits [15:9] equal the bitwise inverse of bits [15:9] of the stored word. Any other write changes nothing: the counter, the stage and the stored word are left as they were.
- R6: While the stored bit 8 is 0, a write is accepted whatever its key is.
- R7: The first expiry sets `nmi_o` and reloads the counter with a grace count of 10 ticks, and the counter keeps running.
- R8: An expiry during the grace stage sets `rst_req_o`. It then stays high until reset, even through later accepted writes.
- R9: An accepted write clears `nmi_o` and returns the block to the first stage, so the next expiry is again a first expiry.
- R10: An accepted write that arrives on the same edge as an expiring tick takes priority. The counter reloads and no expiry takes effect.
- R11: Both outputs are registered. Each one changes on the clock edge where the expiring tick is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control word: key [15:9], run [8], count [7:0]. Upper bits are unused. |
| tick_en | input | 1 | Countdown tick qualifier |
| nmi_o | output | 1 | Non-maskable interrupt, first stage |
| rst_req_o | output | 1 | Sticky system reset request, second stage |

## Verification
A service write and an expiring tick can fall on the same clock edge. The bench provokes this by loading a count of one and then presenting a correctly keyed write together with `tick_en`. It judges the result by checking that `nmi_o` stays low, and that it rises only after the full newly written count of further ticks. The key rule is swept over all 128 key values. Each sweep checks that a repeated key is ignored, that the inverted key is taken, and that the next required key flips back again.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    STG_ARMED   = 2'd0,
    STG_GRACE   = 2'd1,
    STG_TRIPPED = 2'd2
  } wdg_stage_e;

  function automatic logic [8:0] expand_count(input logic [7:0] field);
    expand_count = (field == 8'd0) ? 9'd256 : {1'b0, field};
  endfunction
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
  parameter int KEY_W   = 7,
  parameter int KEY_LSB = 9,
  parameter int CMD_POS = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              accept_o,
  output logic              held_en_o,
  output logic [KEY_W-1:0]  held_key_o
);
  logic             en_q;
  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] new_key;
  logic             key_ok;

  assign new_key = wr_data[KEY_LSB +: KEY_W];
  assign key_ok  = (new_key == ~key_q);
  assign accept_o = wr_valid && (!en_q || key_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      key_q <= '0;
    end else if (accept_o) begin
      en_q  <= wr_data[CMD_POS];
      key_q <= new_key;
    end
  end

  assign held_en_o  = en_q;
  assign held_key_o = key_q;
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int FIELD_W     = 8,
  parameter int GRACE_TICKS = 10,
  localparam int CTR_W      = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] load_val_i,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic               grace_i,
  output logic               expire_o
);
  logic [CTR_W-1:0] cnt_q;
  logic             run_q;
  logic [CTR_W-1:0] load_full;

  assign load_full = (load_val_i == '0) ? CTR_W'(1) << FIELD_W
                                        : {1'b0, load_val_i};
  assign expire_o  = run_q && tick_i && !load_i && (cnt_q == CTR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_full;
      run_q <= run_i;
    end else if (expire_o) begin
      if (grace_i) begin
        cnt_q <= CTR_W'(GRACE_TICKS);
      end else begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - CTR_W'(1);
    end
  end
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic expire_i,
  output logic grace_o,
  output logic nmi_o,
  output logic rst_req_o
);
  wdg_stage_e stage_q;
  logic       nmi_q;
  logic       req_q;

  assign grace_o = (stage_q == STG_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= STG_ARMED;
      nmi_q   <= 1'b0;
      req_q   <= 1'b0;
    end else if (clear_i) begin
      stage_q <= STG_ARMED;
      nmi_q   <= 1'b0;
    end else if (expire_i) begin
      case (stage_q)
        STG_ARMED: begin
          stage_q <= STG_GRACE;
          nmi_q   <= 1'b1;
        end
        STG_GRACE: begin
          stage_q <= STG_TRIPPED;
          req_q   <= 1'b1;
        end
        default: stage_q <= STG_TRIPPED;
      endcase
    end
  end

  assign nmi_o     = nmi_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int DATA_W      = 32,
  parameter int KEY_W       = 7,
  parameter int FIELD_W     = 8,
  parameter int GRACE_TICKS = 10,
  localparam int CMD_POS    = FIELD_W,
  localparam int KEY_LSB    = FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick_en,
  output logic              nmi_o,
  output logic              rst_req_o
);
  logic             wr_ok;
  logic             held_en;
  logic [KEY_W-1:0] held_key;
  logic             expire;
  logic             grace_sel;

  wdg_key_gate #(
    .KEY_W(KEY_W), .KEY_LSB(KEY_LSB), .CMD_POS(CMD_POS), .DATA_W(DATA_W)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .accept_o(wr_ok), .held_en_o(held_en), .held_key_o(held_key)
  );

  wdg_countdown #(
    .FIELD_W(FIELD_W), .GRACE_TICKS(GRACE_TICKS)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(wr_ok),
    .load_val_i(wr_data[FIELD_W-1:0]), .run_i(wr_data[CMD_POS]),
    .tick_i(tick_en), .grace_i(grace_sel), .expire_o(expire)
  );

  wdg_stage u_stage (
    .clk(clk), .rst_n(rst_n), .clear_i(wr_ok), .expire_i(expire),
    .grace_o(grace_sel), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 7,
  parameter int KEY_LSB = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick_en,
  input logic              wr_ok,
  input logic              held_en,
  input logic [KEY_W-1:0]  held_key,
  input logic              nmi_o,
  input logic              rst_req_o
);
  AST_RSTREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> rst_req_o); // R8
  AST_RSTREQ_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> nmi_o); // R8
  AST_NMI_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past(tick_en)); // R2
  AST_WRITE_DROPS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !nmi_o); // R9
  AST_SAME_KEY_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && held_en && wr_data[KEY_LSB +: KEY_W] == held_key) |-> !wr_ok); // R5
  AST_DISARMED_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !held_en) |-> wr_ok); // R6
  AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !wr_ok); // R5
endmodule

bind keyed_watchdog wdg_checker #(
  .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
  .tick_en(tick_en), .wr_ok(wr_ok), .held_en(held_en), .held_key(held_key),
  .nmi_o(nmi_o), .rst_req_o(rst_req_o)
);

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick_en = 1'b0;
  logic        nmi_o;
  logic        rst_req_o;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  keyed_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .tick_en(tick_en), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0b exp=%0b", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_valid = 1'b0; tick_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] word(input int key, input int run, input int cnt);
    word = ((key & 32'h7f) << 9) | ((run & 1) << 8) | (cnt & 32'hff);
  endfunction

  task automatic wr(input int key, input int run, input int cnt);
    wr_valid = 1'b1; wr_data = word(key, run, cnt);
    @(negedge clk);
    wr_valid = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1; @(negedge clk);
      tick_en = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog run not finished got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(nmi_o, 1'b0, "R1", "nmi after reset");
    chk(rst_req_o, 1'b0, "R1", "rst_req after reset");
    ticks(300);
    chk(nmi_o, 1'b0, "R1", "stopped counter after reset");
    // R1 stored word zero: any key is accepted at once
    wr(7'h55, 1, 1); ticks(1);
    chk(nmi_o, 1'b1, "R1", "disarmed after reset accepts any key");

    // R2 R3 R7 R8 R11: count sweep with exact expiry tick
    for (int n = 0; n < 16; n++) begin
      int ld;
      ld = (n == 15) ? 0 : ((n == 14) ? 255 : n + 1);
      do_reset();
      wr(n, 1, ld);
      repeat (25) @(negedge clk);
      chk(nmi_o, 1'b0, "R2", "idle cycles without tick do not count");
      ticks(((ld == 0) ? 256 : ld) - 1);
      chk(nmi_o, 1'b0, (ld == 0) ? "R3" : "R2", "one tick before expiry");
      ticks(1);
      chk(nmi_o, 1'b1, (ld == 0) ? "R3" : "R11", "nmi on the expiring tick");
      chk(rst_req_o, 1'b0, "R7", "no reset request at first expiry");
      ticks(9);
      chk(rst_req_o, 1'b0, "R7", "grace tick 9");
      ticks(1);
      chk(rst_req_o, 1'b1, "R8", "reset request after 10 grace ticks");
      wr((~n) & 7'h7f, 1, 200);
      chk(nmi_o, 1'b0, "R9", "write after reset request clears nmi");
      ticks(5);
      chk(rst_req_o, 1'b1, "R8", "reset request sticky");
    end

    // R5 R9: key sweep over all 128 keys
    for (int k = 0; k < 128; k++) begin
      int inv;
      inv = (~k) & 8'h7f;
      do_reset();
      wr(k, 1, 200);
      wr(k, 1, 2); ticks(2);
      chk(nmi_o, 1'b0, "R5", "same key ignored");
      wr((k + 1) & 7'h7f, 0, 0); ticks(1);
      if (((k + 1) & 7'h7f) != inv)
        chk(nmi_o, 1'b0, "R5", "other key ignored, still counting 200");
      do_reset();
      wr(k, 1, 200);
      wr(inv, 1, 2); ticks(1);
      chk(nmi_o, 1'b0, "R5", "inverted key accepted, one tick left");
      ticks(1);
      chk(nmi_o, 1'b1, "R7", "accepted count expired");
      wr(inv, 1, 1);
      chk(nmi_o, 1'b1, "R5", "repeated inverted key ignored");
      wr(k, 1, 50);
      chk(nmi_o, 1'b0, "R9", "flipped-back key accepted drops nmi");
      ticks(49);
      chk(nmi_o, 1'b0, "R9", "back in first stage");
      ticks(1);
      chk(nmi_o, 1'b1, "R9", "next expiry is a first expiry");
      chk(rst_req_o, 1'b0, "R9", "no reset request after re-arm");
    end

    // R4 R6: stop and disarmed writes
    for (int k = 0; k < 128; k += 9) begin
      do_reset();
      wr(k, 1, 3);
      wr((~k) & 7'h7f, 0, 3);
      ticks(40);
      chk(nmi_o, 1'b0, "R4", "stopped counter never expires");
      wr(k + 5, 1, 2); ticks(1);
      chk(nmi_o, 1'b0, "R6", "disarmed accepts arbitrary key (1 tick)");
      ticks(1);
      chk(nmi_o, 1'b1, "R6", "disarmed write started counter");
    end

    // R10: write and expiring tick on the same edge
    do_reset();
    wr(3, 1, 1);
    tick_en = 1'b1; wr_valid = 1'b1; wr_data = word(7'h7c, 1, 5);
    @(negedge clk);
    tick_en = 1'b0; wr_valid = 1'b0; wr_data = '0;
    chk(nmi_o, 1'b0, "R10", "write wins over expiring tick");
    ticks(4);
    chk(nmi_o, 1'b0, "R10", "reloaded count 5, four ticks");
    ticks(1);
    chk(nmi_o, 1'b1, "R10", "expiry after the new count");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule